// File: doc/BRIEF.md
# Predicated Register-Vector Issue Sequencer

This block sits after instruction decode. It turns one scalar-encoded integer add into a sequence of element operations when its operand registers carry a vector tag. Each cycle it produces at most one register-file write request. The request carries the destination index and the sum of the two source registers. The source registers are read through two combinational read ports, and the block computes their indices. A destination, first-source or second-source index steps by one per element only if that register is tagged. An untagged register is reused for every element. This lets one loop cover the scalar/scalar, scalar/vector and vector/vector forms.

A small table of predicate entries is searched using the destination register. A matching entry names an integer register whose bits enable individual elements. The entry can also invert those bits. Disabled elements still consume their cycle slot but write nothing, so their destination keeps its old contents. An operation whose three registers are all untagged is issued exactly once, in the cycle it is accepted, like an ordinary scalar instruction.

Top module: `vec_issue_seq`

## Requirements
- R1: A new operation is accepted only when `start` is high and `busy` is low. A `start` pulse, or any change to the operation, tag or length inputs, while `busy` is high has no effect on the operation in progress.
- R2: For an operation with at least one tagged register, the element count is the minimum of `vl`, `dst_len` and XLEN. Element slots are taken one per cycle, starting at index 0 in the accept cycle.
- R3: For each of the destination, first source and second source, the index used for element i is the base register plus i when that register's bit in `vec_tag` is 1, and the base register otherwise. Indices wrap modulo the register count.
- R4: An element whose enable bit is 0 issues no write, so its destination register keeps its value. It still uses its cycle slot.
- R5: A predicate entry is NPRED fields of 13 bits, with entry k at bits [13k+12:13k]. Inside an entry, bit 12 is valid, bit 11 is the file selector compared with `op_fp`, bits 10:6 are the key compared with `rd`, bits 5:1 are the predicate register, and bit 0 is invert. The lowest-numbered valid matching entry wins, and its predicate register is read through `pred_addr` in the accept cycle.
- R6: When the winning entry's invert bit is set, the complement of the predicate register is used as the enable mask.
- R7: When no entry matches, every element is enabled.
- R8: When all three registers are untagged, exactly one write is issued in the accept cycle. `done` is high in that same cycle and `busy` stays low. Predicate and length are ignored.
- R9: `done` is high in the cycle of the final element slot. It is also high in the accept cycle when the element count is 0, and in that case no write is issued. `busy` is high from the cycle after acceptance up to and including the final slot.
- R10: `wr_data` equals `rs1_data + rs2_data` modulo 2^XLEN, read at `rs1_addr` and `rs2_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operation offered |
| op_fp | input | 1 | Register-file selector of the operation, used for table matching |
| rd | input | 5 | Destination base register |
| rs1 | input | 5 | First source base register |
| rs2 | input | 5 | Second source base register |
| vec_tag | input | 32 | One vector tag bit per register |
| vl | input | 6 | Global vector length |
| dst_len | input | 6 | Vector length attached to the destination register |
| pred_tab | input | 52 | Predicate table, four 13-bit entries |
| pred_addr | output | 5 | Predicate register read index |
| pred_data | input | 32 | Predicate register contents |
| rs1_addr | output | 5 | First source read index |
| rs1_data | input | 32 | First source read data |
| rs2_addr | output | 5 | Second source read index |
| rs2_data | input | 32 | Second source read data |
| wr_en | output | 1 | Element write request |
| wr_addr | output | 5 | Element destination index |
| wr_data | output | 32 | Element result |
| busy | output | 1 | Multi-cycle operation in progress |
| done | output | 1 | Final element slot of the operation this cycle |

## Verification
The assertions assume that the register-file and predicate read ports answer within the same cycle. They also assume that `start` is only examined when the sequencer is idle. The bench meets both conditions: it models the register file as a combinational array that is written at the clock edge, and it changes inputs only just after an edge. During busy periods the bench deliberately holds `start` high with altered operands, tags and lengths. The captured operation must therefore come only from the accept cycle.

// File: rtl/vec_issue_seq.sv
module vec_issue_seq #(
  parameter int XLEN  = 32,
  parameter int NREG  = 32,
  parameter int NPRED = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      op_fp,
  input  logic [$clog2(NREG)-1:0]   rd,
  input  logic [$clog2(NREG)-1:0]   rs1,
  input  logic [$clog2(NREG)-1:0]   rs2,
  input  logic [NREG-1:0]           vec_tag,
  input  logic [$clog2(XLEN+1)-1:0] vl,
  input  logic [$clog2(XLEN+1)-1:0] dst_len,
  input  logic [NPRED*(2*$clog2(NREG)+3)-1:0] pred_tab,
  output logic [$clog2(NREG)-1:0]   pred_addr,
  input  logic [XLEN-1:0]           pred_data,
  output logic [$clog2(NREG)-1:0]   rs1_addr,
  input  logic [XLEN-1:0]           rs1_data,
  output logic [$clog2(NREG)-1:0]   rs2_addr,
  input  logic [XLEN-1:0]           rs2_data,
  output logic                      wr_en,
  output logic [$clog2(NREG)-1:0]   wr_addr,
  output logic [XLEN-1:0]           wr_data,
  output logic                      busy,
  output logic                      done
);
  localparam int RW = $clog2(NREG);
  localparam int LW = $clog2(XLEN+1);
  localparam int IW = $clog2(XLEN);
  localparam int EW = 2*RW + 3;

  logic          busy_q;
  logic [LW-1:0] idx_q, n_q;
  logic [XLEN-1:0] mask_q;
  logic [RW-1:0] d_q, a_q, b_q;
  logic          vd_q, va_q, vb_q;

  logic          hit, pinv;
  logic [RW-1:0] psel;
  logic [EW-1:0] ent;

  always_comb begin
    hit  = 1'b0;
    pinv = 1'b0;
    psel = '0;
    ent  = '0;
    for (int k = NPRED-1; k >= 0; k--) begin
      ent = pred_tab[k*EW +: EW];
      if (ent[EW-1] && ent[EW-2] == op_fp && ent[EW-3 -: RW] == rd) begin
        hit  = 1'b1;
        psel = ent[RW:1];
        pinv = ent[0];
      end
    end
  end
  assign pred_addr = psel;

  wire          tv_d  = vec_tag[rd];
  wire          tv_a  = vec_tag[rs1];
  wire          tv_b  = vec_tag[rs2];
  wire          allsc = !(tv_d || tv_a || tv_b);
  wire [LW-1:0] m_len = (vl < dst_len) ? vl : dst_len;
  wire [LW-1:0] n_new = allsc ? LW'(1) : ((m_len > LW'(XLEN)) ? LW'(XLEN) : m_len);
  wire [XLEN-1:0] mask_new = (allsc || !hit) ? '1 : (pinv ? ~pred_data : pred_data);

  wire take   = start && !busy_q;
  wire active = take || busy_q;

  wire [LW-1:0]   cur_i    = busy_q ? idx_q  : '0;
  wire [LW-1:0]   cur_n    = busy_q ? n_q    : n_new;
  wire [XLEN-1:0] cur_mask = busy_q ? mask_q : mask_new;
  wire [RW-1:0]   cur_d    = busy_q ? d_q    : rd;
  wire [RW-1:0]   cur_a    = busy_q ? a_q    : rs1;
  wire [RW-1:0]   cur_b    = busy_q ? b_q    : rs2;
  wire            cur_vd   = busy_q ? vd_q   : tv_d;
  wire            cur_va   = busy_q ? va_q   : tv_a;
  wire            cur_vb   = busy_q ? vb_q   : tv_b;

  wire el_ok = cur_i < cur_n;
  wire last  = (cur_i + LW'(1)) >= cur_n;

  assign wr_en    = active && el_ok && cur_mask[cur_i[IW-1:0]];
  assign wr_addr  = cur_d;
  assign rs1_addr = cur_a;
  assign rs2_addr = cur_b;
  assign wr_data  = rs1_data + rs2_data;
  assign done     = active && last;
  assign busy     = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      n_q    <= '0;
      mask_q <= '0;
      d_q    <= '0;
      a_q    <= '0;
      b_q    <= '0;
      vd_q   <= 1'b0;
      va_q   <= 1'b0;
      vb_q   <= 1'b0;
    end else if (active) begin
      busy_q <= !last;
      idx_q  <= cur_i + LW'(1);
      d_q    <= cur_d + RW'(cur_vd);
      a_q    <= cur_a + RW'(cur_va);
      b_q    <= cur_b + RW'(cur_vb);
      if (take) begin
        n_q    <= n_new;
        mask_q <= mask_new;
        vd_q   <= tv_d;
        va_q   <= tv_a;
        vb_q   <= tv_b;
      end
    end
  end

  // R1
  hold_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done) |=> ($stable(n_q) && $stable(mask_q) && $stable(vd_q)));

  // R2
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (idx_q < n_q));

  // R3
  dst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> (d_q == $past(d_q) + RW'($past(vd_q))));

  // R4
  skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !mask_q[idx_q[IW-1:0]]) |-> !wr_en);

  // R8
  scalar_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q && !(vec_tag[rd] || vec_tag[rs1] || vec_tag[rs2])) |-> (wr_en && done) ##1 !busy_q);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);
endmodule

// File: tb/tb_vec_issue_seq.sv
module tb_vec_issue_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NOPS = 10;

  // [31] noise, [30] fp, [29:25] rd, [24:20] rs1, [19:15] rs2, [14:12] tags d/a/b, [11:6] vl, [5:0] dst_len
  localparam logic [31:0] TBL [NOPS] = '{
    {1'b1, 1'b0, 5'd8,  5'd20, 5'd24, 3'b111, 6'd8,  6'd8},
    {1'b0, 1'b0, 5'd16, 5'd8,  5'd0,  3'b110, 6'd6,  6'd10},
    {1'b1, 1'b0, 5'd10, 5'd11, 5'd12, 3'b000, 6'd0,  6'd0},
    {1'b0, 1'b0, 5'd24, 5'd5,  5'd28, 3'b101, 6'd5,  6'd3},
    {1'b0, 1'b0, 5'd12, 5'd13, 5'd14, 3'b010, 6'd4,  6'd4},
    {1'b0, 1'b0, 5'd8,  5'd20, 5'd24, 3'b111, 6'd0,  6'd8},
    {1'b0, 1'b0, 5'd30, 5'd26, 5'd29, 3'b111, 6'd6,  6'd6},
    {1'b0, 1'b1, 5'd20, 5'd9,  5'd15, 3'b111, 6'd4,  6'd4},
    {1'b0, 1'b0, 5'd20, 5'd9,  5'd15, 3'b111, 6'd3,  6'd3},
    {1'b1, 1'b0, 5'd8,  5'd9,  5'd0,  3'b110, 6'd40, 6'd40}
  };

  logic clk = 0, rst_n = 0, start = 0, op_fp = 0;
  logic [4:0] rd = 0, rs1 = 0, rs2 = 0;
  logic [31:0] vec_tag = 0;
  logic [5:0] vl = 0, dst_len = 0;
  logic [51:0] pred_tab;
  logic [4:0] pred_addr, rs1_addr, rs2_addr, wr_addr;
  logic [31:0] pred_data, rs1_data, rs2_data, wr_data;
  logic wr_en, busy, done;

  logic [31:0] rf [32];
  logic [31:0] g  [32];
  int checks = 0, fails = 0;
  string req_of [NOPS];

  logic       e_fp   [4] = '{1'b0, 1'b0, 1'b1, 1'b0};
  logic [4:0] e_key  [4] = '{5'd8, 5'd16, 5'd20, 5'd8};
  logic [4:0] e_preg [4] = '{5'd1, 5'd2, 5'd3, 5'd4};
  logic       e_inv  [4] = '{1'b0, 1'b1, 1'b0, 1'b0};

  assign pred_tab = {1'b1, 1'b0, 5'd8, 5'd4, 1'b0,
                     1'b1, 1'b1, 5'd20, 5'd3, 1'b0,
                     1'b1, 1'b0, 5'd16, 5'd2, 1'b1,
                     1'b1, 1'b0, 5'd8, 5'd1, 1'b0};
  assign pred_data = rf[pred_addr];
  assign rs1_data  = rf[rs1_addr];
  assign rs2_data  = rf[rs2_addr];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (wr_en) rf[wr_addr] <= wr_data;

  vec_issue_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_fp(op_fp),
    .rd(rd), .rs1(rs1), .rs2(rs2), .vec_tag(vec_tag), .vl(vl), .dst_len(dst_len),
    .pred_tab(pred_tab), .pred_addr(pred_addr), .pred_data(pred_data),
    .rs1_addr(rs1_addr), .rs1_data(rs1_data), .rs2_addr(rs2_addr), .rs2_data(rs2_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .done(done));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input int k);
    logic [31:0] e = TBL[k];
    logic noisy = e[31], fp = e[30];
    logic [4:0] d = e[29:25], a = e[24:20], b = e[19:15];
    logic vd = e[14], va = e[13], vb = e[12];
    int n, lat, exp_lat, bad;
    logic [31:0] mask;
    bit matched;
    if (!(vd || va || vb)) begin
      g[d] = g[a] + g[b];
      exp_lat = 0;
    end else begin
      n = (e[11:6] < e[5:0]) ? int'(e[11:6]) : int'(e[5:0]);
      if (n > 32) n = 32;
      mask = '1;
      matched = 0;
      for (int j = 0; j < 4; j++)
        if (!matched && e_fp[j] == fp && e_key[j] == d) begin
          matched = 1;
          mask = e_inv[j] ? ~g[e_preg[j]] : g[e_preg[j]];
        end
      for (int i = 0; i < n; i++) begin
        if (mask[i]) g[d] = g[a] + g[b];
        d = d + 5'(vd); a = a + 5'(va); b = b + 5'(vb);
      end
      exp_lat = (n == 0) ? 0 : n - 1;
    end
    @(negedge clk);
    op_fp = fp; rd = e[29:25]; rs1 = e[24:20]; rs2 = e[19:15];
    vec_tag = '0;
    vec_tag[e[29:25]] = vd; vec_tag[e[24:20]] = va; vec_tag[e[19:15]] = vb;
    vl = e[11:6]; dst_len = e[5:0];
    start = 1;
    lat = 0;
    #1;
    while (!done && lat < 100) begin
      @(posedge clk); #1;
      lat++;
      if (lat == 1) check(busy == 1'b1, "R9 busy after accept", busy, 1);
      if (noisy) begin
        rd = rd ^ 5'd5; rs1 = rs1 ^ 5'd3; vec_tag = ~vec_tag; vl = 6'd2; op_fp = ~op_fp;
      end else start = 0;
    end
    check(lat == exp_lat, {req_of[k], " done latency"}, lat, exp_lat);
    @(posedge clk); #1;
    start = 0;
    #1;
    check(busy == 1'b0, "R9 idle after done", busy, 0);
    bad = 0;
    for (int r = 0; r < 32; r++)
      if (rf[r] !== g[r]) begin
        bad++;
        $display("FAIL %s reg %0d actual=%0h expected=%0h", req_of[k], r, rf[r], g[r]);
      end
    checks++;
    if (bad != 0) fails++;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    req_of = '{"R2 R3 R5 R1", "R6 R3 R2", "R8 R1", "R7 R2 R3", "R3 scalar dst",
               "R9 zero count", "R10 R3 wrap", "R5 fp select", "R7 file mismatch", "R2 R1 clamp"};
    for (int r = 0; r < 32; r++) rf[r] = 32'h0102_0305 * r + 32'h0000_0007;
    rf[1] = 32'hA5A5_5A5A;
    rf[2] = 32'h0000_00F0;
    rf[3] = 32'h0000_000B;
    rf[4] = 32'h0000_0000;
    for (int r = 0; r < 32; r++) g[r] = rf[r];
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    check(busy == 1'b0, "R9 reset busy", busy, 0);
    check(done == 1'b0, "R9 reset done", done, 0);
    check(wr_en == 1'b0, "R1 reset no write", wr_en, 0);
    for (int k = 0; k < NOPS; k++) run_op(k);
    @(negedge clk);
    check(wr_en == 1'b0 && done == 1'b0, "R1 idle without start", {wr_en, done}, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule